// File: doc/BRIEF.md
# Periodic Rank Refresh Scheduler

This block sets the refresh pace for one DRAM rank. A free-running interval timer earns one refresh credit per average refresh period. Every retention window of 64 ms needs 8K commands, so the period is about 7.8 us. Owed credits raise a request toward the command scheduler. When the scheduler has drained the rank, it answers with a quiesce acknowledge. The block then emits a one-cycle refresh command tagged with the row-group index it covers. It also holds the rank blocked for the refresh duration, 320 ns for a 64-row group: eight rows in each of eight banks working in parallel.

The row-group index runs through every group of the rank and returns to zero. A window-done pulse marks the command that completes a full pass. The scheduler may hold off refresh for a while, and a small number of credits can be owed. A credit that arrives when the owed count is already at its limit is lost, and a sticky error flag records it. All periods are given in nanoseconds and converted to clock cycles from the clock period parameter.

Top module: `rfsh_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_o`, `ref_cmd_o`, `busy_o`, `window_done_o` and `owe_err_o` are 0 and `group_o` is 0.
- R2: A credit is earned on every INTERVAL-th clock edge after reset release, where INTERVAL = REFRESH_INTERVAL_NS*1000/CLK_PERIOD_PS. With no command issued, `req_o` is 0 after edge INTERVAL-1 and 1 after edge INTERVAL.
- R3: `ref_cmd_o` is 1 in a cycle only if `req_o` and `quiesced_i` were both 1 in the cycle before. While `quiesced_i` stays 0, no command issues and `req_o` stays 1.
- R4: `ref_cmd_o` is a single-cycle pulse. `busy_o` rises in that same cycle and stays 1 for exactly BUSY = REFRESH_BUSY_NS*1000/CLK_PERIOD_PS cycles.
- R5: `req_o` is 0 whenever `busy_o` is 1.
- R6: `group_o` is a binary row-group index. It holds the group of the most recent command, stays stable between commands, and steps by one per command, from ROW_GROUPS-1 back to 0. The first command after reset carries group 0.
- R7: `window_done_o` is 1 only together with a `ref_cmd_o` whose `group_o` equals ROW_GROUPS-1.
- R8: Up to MAX_OWED credits are kept. With the acknowledge held, they drain as back-to-back commands spaced BUSY+1 cycles apart.
- R9: A credit that arrives with MAX_OWED already owed and no command issuing in that cycle sets `owe_err_o`. The flag stays 1 until reset, and the owed count stays at MAX_OWED.
- R10: `quiesced_i` has no effect while no credit is owed: no command issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| quiesced_i | input | 1 | Scheduler acknowledge: the rank is idle and refresh may start |
| req_o | output | 1 | Refresh is owed and the rank is not already refreshing |
| ref_cmd_o | output | 1 | One-cycle refresh command |
| busy_o | output | 1 | Rank blocked by a refresh in progress |
| group_o | output | GROUP_W | Row-group index of the latest command |
| window_done_o | output | 1 | Pulse with the command covering the last row group |
| owe_err_o | output | 1 | Sticky flag: a credit was lost to the owed-credit limit |

## Verification
The bench builds the block with an 8 ns clock period, a 160 ns interval and a 40 ns busy time, which gives 20 and 5 cycles. It uses 5 row groups and an owed limit of 3. These values let one run cover several full index passes through the non-power-of-two wrap variant, a three-credit backlog drained at minimum spacing, and an owed-limit overflow, all in a few hundred cycles. The default power-of-two group count is covered by elaboration only.

// File: rtl/rfsh_pkg.sv
`timescale 1ns/1ps
package rfsh_pkg;

   // Convert a duration in ns to whole clock cycles.
   function automatic int unsigned ns_to_cycles(int unsigned dur_ns, int unsigned period_ps);
      return (dur_ns * 1000) / period_ps;
   endfunction

   function automatic bit is_pow2(int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic int unsigned width_for(int unsigned max_val);
      return (max_val > 1) ? $clog2(max_val + 1) : 1;
   endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
`timescale 1ns/1ps
module rfsh_interval_timer #(
   parameter int unsigned PERIOD = 6240
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic tick_o
);
   localparam int unsigned CW = rfsh_pkg::width_for(PERIOD - 1);
   localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
   end

   assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/rfsh_credit.sv
`timescale 1ns/1ps
module rfsh_credit #(
   parameter int unsigned MAX_OWED = 8
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic take_i,
   output logic pending_o,
   output logic overflow_o
);
   localparam int unsigned OW = rfsh_pkg::width_for(MAX_OWED);
   localparam logic [OW-1:0] FULL = OW'(MAX_OWED);

   logic [OW-1:0] owed_q;
   logic          err_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         owed_q <= '0;
         err_q  <= 1'b0;
      end else begin
         unique case ({tick_i, take_i})
            2'b10: begin
               if (owed_q == FULL) err_q  <= 1'b1;
               else                owed_q <= owed_q + 1'b1;
            end
            2'b01:   owed_q <= owed_q - 1'b1;
            default: ;
         endcase
      end
   end

   assign pending_o  = (owed_q != '0);
   assign overflow_o = err_q;
endmodule

// File: rtl/rfsh_busy_timer.sv
`timescale 1ns/1ps
module rfsh_busy_timer #(
   parameter int unsigned HOLD = 256
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic busy_o
);
   localparam int unsigned BW = rfsh_pkg::width_for(HOLD);
   localparam logic [BW-1:0] LOAD = BW'(HOLD);

   logic [BW-1:0] left_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             left_q <= '0;
      else if (start_i)        left_q <= LOAD;
      else if (left_q != '0)   left_q <= left_q - 1'b1;
   end

   assign busy_o = (left_q != '0);
endmodule

// File: rtl/rfsh_group_ctr.sv
`timescale 1ns/1ps
module rfsh_group_ctr #(
   parameter int unsigned GROUPS = 8192,
   localparam int unsigned GW = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          step_i,
   output logic [GW-1:0] group_o,
   output logic          wrap_o
);
   localparam logic [GW-1:0] LAST = GW'(GROUPS - 1);

   logic [GW-1:0] next_q, next_inc, grp_q;
   logic          wrap_q;

   generate
      if (rfsh_pkg::is_pow2(GROUPS)) begin : g_natural_wrap
         assign next_inc = next_q + 1'b1;
      end else begin : g_compare_wrap
         assign next_inc = (next_q == LAST) ? '0 : next_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         next_q <= '0;
         grp_q  <= '0;
         wrap_q <= 1'b0;
      end else begin
         wrap_q <= step_i && (next_q == LAST);
         if (step_i) begin
            grp_q  <= next_q;
            next_q <= next_inc;
         end
      end
   end

   assign group_o = grp_q;
   assign wrap_o  = wrap_q;
endmodule

// File: rtl/rfsh_sched.sv
`timescale 1ns/1ps
module rfsh_sched #(
   parameter int unsigned CLK_PERIOD_PS       = 1250,
   parameter int unsigned REFRESH_INTERVAL_NS = 7800,
   parameter int unsigned REFRESH_BUSY_NS     = 320,
   parameter int unsigned ROW_GROUPS          = 8192,
   parameter int unsigned MAX_OWED            = 8,
   localparam int unsigned GROUP_W = (ROW_GROUPS > 1) ? $clog2(ROW_GROUPS) : 1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               quiesced_i,
   output logic               req_o,
   output logic               ref_cmd_o,
   output logic               busy_o,
   output logic [GROUP_W-1:0] group_o,
   output logic               window_done_o,
   output logic               owe_err_o
);
   localparam int unsigned INTERVAL_CYC = rfsh_pkg::ns_to_cycles(REFRESH_INTERVAL_NS, CLK_PERIOD_PS);
   localparam int unsigned BUSY_CYC     = rfsh_pkg::ns_to_cycles(REFRESH_BUSY_NS, CLK_PERIOD_PS);

   // Elaboration checks on the parameter set.
   if (BUSY_CYC < 1) begin : g_chk_busy
      $error("refresh busy time is shorter than one clock");
   end
   if (INTERVAL_CYC <= BUSY_CYC + 1) begin : g_chk_interval
      $error("refresh interval must exceed busy time plus one cycle");
   end
   if (ROW_GROUPS < 2) begin : g_chk_groups
      $error("at least two row groups are required");
   end
   if (MAX_OWED < 1) begin : g_chk_owed
      $error("owed-credit limit must be at least one");
   end

   logic tick, pending, busy, issue, cmd_q;

   rfsh_interval_timer #(.PERIOD(INTERVAL_CYC)) u_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_o (tick)
   );

   rfsh_credit #(.MAX_OWED(MAX_OWED)) u_credit (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick),
      .take_i     (issue),
      .pending_o  (pending),
      .overflow_o (owe_err_o)
   );

   rfsh_busy_timer #(.HOLD(BUSY_CYC)) u_busy (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (issue),
      .busy_o  (busy)
   );

   rfsh_group_ctr #(.GROUPS(ROW_GROUPS)) u_group (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .step_i  (issue),
      .group_o (group_o),
      .wrap_o  (window_done_o)
   );

   assign req_o = pending && !busy;
   assign issue = req_o && quiesced_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cmd_q <= 1'b0;
      else         cmd_q <= issue;
   end

   assign ref_cmd_o = cmd_q;
   assign busy_o    = busy;
endmodule

// File: rtl/rfsh_sched_chk.sv
`timescale 1ns/1ps
module rfsh_sched_chk #(
   parameter int unsigned ROW_GROUPS = 8192,
   parameter int unsigned GROUP_W    = 13
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               quiesced_i,
   input logic               req_o,
   input logic               ref_cmd_o,
   input logic               busy_o,
   input logic [GROUP_W-1:0] group_o,
   input logic               window_done_o,
   input logic               owe_err_o
);
   a_r3_cmd_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ref_cmd_o |-> $past(req_o && quiesced_i));

   a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ref_cmd_o |=> !ref_cmd_o);

   a_r4_busy_with_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ref_cmd_o |-> busy_o);

   a_r5_no_req_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |-> !req_o);

   a_r6_group_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ref_cmd_o |-> $stable(group_o));

   a_r7_wrap_last_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
      window_done_o |-> (ref_cmd_o && group_o == GROUP_W'(ROW_GROUPS - 1)));

   a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      owe_err_o |=> owe_err_o);
endmodule

bind rfsh_sched rfsh_sched_chk #(.ROW_GROUPS(ROW_GROUPS), .GROUP_W(GROUP_W)) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .quiesced_i    (quiesced_i),
   .req_o         (req_o),
   .ref_cmd_o     (ref_cmd_o),
   .busy_o        (busy_o),
   .group_o       (group_o),
   .window_done_o (window_done_o),
   .owe_err_o     (owe_err_o)
);

// File: tb/test_rfsh_sched.sv
`timescale 1ns/1ps
module test_rfsh_sched;
   localparam int unsigned GROUPS = 5;
   localparam int unsigned BUSY   = 5;
   localparam int unsigned GW     = $clog2(GROUPS);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ack = 1'b0;
   logic          req, cmd, busy, wdone, err;
   logic [GW-1:0] grp;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int cmd_cnt = 0;
   int r5_viol = 0;
   bit done = 0;

   typedef struct { int g; bit w; } exp_t;
   exp_t exp_q[$];

   always #4 clk = ~clk;

   rfsh_sched #(
      .CLK_PERIOD_PS(8000), .REFRESH_INTERVAL_NS(160), .REFRESH_BUSY_NS(40),
      .ROW_GROUPS(GROUPS), .MAX_OWED(3)
   ) i_rfsh_sched (
      .clk_i(clk), .rst_ni(rst_n), .quiesced_i(ack), .req_o(req),
      .ref_cmd_o(cmd), .busy_o(busy), .group_o(grp),
      .window_done_o(wdone), .owe_err_o(err)
   );

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
      end
   endtask

   task automatic expect_cmd(input int g);
      exp_t e;
      e.g = g;
      e.w = (g == GROUPS - 1);
      exp_q.push_back(e);
   endtask

   task automatic to_edge(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   // Monitor: snapshot after each edge, inputs already set for the next edge.
   bit prev_ra = 0, prev_cmd = 0;
   int busy_run = 0;
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         if (req && busy) r5_viol++;
         if (wdone && !cmd) chk(0, "R7 window_done without command", 1, 0);
         if (cmd) begin
            cmd_cnt++;
            chk(prev_ra, "R3 command without prior req and ack", 0, 1);
            chk(!prev_cmd, "R4 command pulse longer than one cycle", 2, 1);
            chk(busy, "R4 busy with command", busy, 1);
            if (exp_q.size() == 0) begin
               chk(0, "R6 unexpected command", 1, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk(int'(grp) == e.g, "R6 group index", int'(grp), e.g);
               chk(wdone == e.w, "R7 window_done", wdone, e.w);
            end
         end
         if (busy) busy_run++;
         else if (busy_run != 0) begin
            chk(busy_run == BUSY, "R4 busy length", busy_run, BUSY);
            busy_run = 0;
         end
         prev_ra  = req && ack;
         prev_cmd = cmd;
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(8 * 5000);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 330);
      finish_run();
   end

   initial begin
      int c0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(req == 0 && cmd == 0 && busy == 0, "R1 control outputs in reset", {req, cmd, busy}, 0);
      chk(wdone == 0 && err == 0 && grp == 0, "R1 flags and group in reset", {wdone, err, 1'b0} | int'(grp), 0);
      rst_n = 1'b1;
      to_edge(1);
      chk(req == 0 && cmd == 0 && busy == 0 && grp == 0, "R1 first cycle after reset", req, 0);
      // R10: acknowledge with nothing owed
      ack = 1'b1;
      to_edge(9);
      ack = 1'b0;
      to_edge(19);
      chk(req == 0, "R2 no request before interval", req, 0);
      to_edge(20);
      chk(req == 1, "R2 request at interval", req, 1);
      to_edge(21);
      chk(cmd_cnt == 0, "R10 ack without credit ignored", cmd_cnt, 0);
      chk(req == 1, "R3 request held while unacknowledged", req, 1);
      to_edge(22);
      // steady cadence: commands at 23,41,61,81,101,121
      for (int g = 0; g < 6; g++) expect_cmd(g % GROUPS);
      ack = 1'b1;
      to_edge(121);
      ack = 1'b0;
      to_edge(181);
      chk(cmd_cnt == 6, "R6 steady command count", cmd_cnt, 6);
      chk(err == 0, "R9 no error at exactly MAX_OWED", err, 0);
      chk(req == 1, "R8 backlog requested", req, 1);
      // backlog of 3 drains at 182,188,194; tick-driven one at 201
      c0 = cmd_cnt;
      for (int g = 1; g <= 4; g++) expect_cmd(g);
      ack = 1'b1;
      to_edge(199);
      chk(cmd_cnt - c0 == 3, "R8 back-to-back drain", cmd_cnt - c0, 3);
      to_edge(201);
      ack = 1'b0;
      to_edge(279);
      chk(err == 0, "R9 error still clear", err, 0);
      to_edge(280);
      chk(err == 1, "R9 overflow sets error", err, 1);
      to_edge(285);
      // saturated backlog of 3 at 286,292,298, then one at 304
      for (int g = 0; g < 4; g++) expect_cmd(g);
      ack = 1'b1;
      to_edge(305);
      ack = 1'b0;
      to_edge(330);
      chk(err == 1, "R9 error sticky", err, 1);
      chk(cmd_cnt == 14, "R8 total commands with saturated credit", cmd_cnt, 14);
      chk(exp_q.size() == 0, "R6 all expected commands seen", exp_q.size(), 0);
      chk(r5_viol == 0, "R5 request during busy", r5_viol, 0);
      finish_run();
   end
endmodule